// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits between a host I/O port bus and a configuration target. It exposes two 32-bit I/O locations. The first one is a select register. Software writes it with the bus, device, function and dword register number it wants to reach, plus an enable flag. The second location is not storage. Every read or write of it launches one configuration access toward the downstream target, aimed at the location held in the select register. Read data comes back to the host, and write data is forwarded to the target.

The host bus uses a request/acknowledge scheme. The host raises a read or write strobe with an address, byte enables and write data. It holds them until the block returns a one-cycle ready pulse, and read data is valid during that pulse. Downstream, the block holds a request with the target coordinates until the target signals done. If no answer arrives within a fixed window of cycles, the block ends the access itself, so the host never hangs on an absent device.

Top module: `cfg_port_bridge`

## Requirements
- R1: Only the exact 16-bit I/O addresses 0xCF8 (select register) and 0xCFC (data port) are decoded. An access to any other address starts no configuration request, returns io_rdata of zero and still completes with a ready pulse one cycle after the strobe is seen.
- R2: The select register keeps the enable flag in bit 31, the bus number in bits 23:16, the device in bits 15:11, the function in bits 10:8 and the dword register number in bits 7:2. Bits 30:24 and 1:0 always read as zero. A write updates only the bytes whose io_be bit is set (io_be[n] covers bits 8n+7:8n).
- R3: A write to the select register never raises cfg_req.
- R4: The select register reads back through 0xCF8, and reset clears it to zero.
- R5: A data port read with the enable flag set raises exactly one request with cfg_we low. The request carries the bus, device, function and register fields from the select register and io_be on cfg_be. The host receives the cfg_rdata value present when cfg_done is high.
- R6: A data port write with the enable flag set raises one request with cfg_we high, carrying io_wdata on cfg_wdata and io_be on cfg_be.
- R7: With the enable flag clear, a data port access starts no request. A read returns 0xFFFFFFFF and a write is discarded. Both complete one cycle after the strobe is seen.
- R8: io_ready stays low while a request is pending. It pulses high for exactly one cycle, in the cycle after cfg_done. io_rdata is zero whenever io_ready is low.
- R9: If cfg_done has not arrived after cfg_req has been high for TIMEOUT (default 64) cycles, the request is withdrawn and the access completes. A read then returns 0xFFFFFFFF. A cfg_done in the last cycle of the window still delivers the target's data.
- R10: While cfg_req is high, every request field (target select, register, byte enables, direction, write data) stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | IO_ADDR_W (16) | Host I/O port address |
| io_rd | input | 1 | Host read strobe, held until io_ready |
| io_wr | input | 1 | Host write strobe, held until io_ready |
| io_be | input | 4 | Host byte enables |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Read data, valid with io_ready |
| io_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Request direction, 1 = write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Dword register offset (0 to 63) |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Data for configuration writes |
| cfg_rdata | input | 32 | Data from the target, sampled with cfg_done |
| cfg_done | input | 1 | Target completion |

## Verification
The hardest situation to reach is the race at the edge of the timeout window, where the target answers in exactly the last cycle before the block would give up. An error of one cycle in the window count is invisible unless the answer lands on that boundary. The bench models the target with a programmable answer delay, and it selects a device number that the model never answers. It drives one read that times out fully and one answered with a delay of TIMEOUT-1 cycles, then compares the completion latency and the returned data of the two.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned BYTES_W = WORD_W / 8;

   // Writable bits of the select register; everything else reads zero.
   localparam logic [WORD_W-1:0] SEL_WMASK = 32'h80FF_FFFC;

   localparam int unsigned SEL_EN_BIT  = 31;
   localparam int unsigned SEL_BUS_LSB = 16;
   localparam int unsigned SEL_DEV_LSB = 11;
   localparam int unsigned SEL_FN_LSB  = 8;
   localparam int unsigned SEL_REG_LSB = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RESP = 2'd2
   } bridge_state_e;

endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode #(
   parameter int unsigned IO_ADDR_W = 16,
   parameter int unsigned SEL_PORT  = 32'h0CF8,
   parameter int unsigned DAT_PORT  = 32'h0CFC
) (
   input  logic [IO_ADDR_W-1:0] io_addr,
   output logic                 hit_sel,
   output logic                 hit_dat
);

   localparam logic [IO_ADDR_W-1:0] SEL_A = IO_ADDR_W'(SEL_PORT);
   localparam logic [IO_ADDR_W-1:0] DAT_A = IO_ADDR_W'(DAT_PORT);

   if (IO_ADDR_W < 3 || IO_ADDR_W > 31) begin : g_bad_width
      $error("cfg_io_decode: IO_ADDR_W out of range");
   end
   if (SEL_PORT == DAT_PORT) begin : g_bad_same
      $error("cfg_io_decode: the two ports must differ");
   end
   if ((SEL_PORT % 4) != 0 || (DAT_PORT % 4) != 0) begin : g_bad_align
      $error("cfg_io_decode: ports must be dword aligned");
   end
   if (SEL_PORT >= (32'd1 << IO_ADDR_W) || DAT_PORT >= (32'd1 << IO_ADDR_W)) begin : g_bad_fit
      $error("cfg_io_decode: port does not fit the address width");
   end

   assign hit_sel = (io_addr == SEL_A);
   assign hit_dat = (io_addr == DAT_A);

endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
   import cfg_port_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [BYTES_W-1:0] wr_be,
   input  logic [WORD_W-1:0]  wr_data,
   output logic [WORD_W-1:0]  sel_word
);

   logic [WORD_W-1:0] sel_q;

   for (genvar b = 0; b < BYTES_W; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q[8*b +: 8] <= '0;
         end else if (wr_en && wr_be[b]) begin
            sel_q[8*b +: 8] <= wr_data[8*b +: 8] & SEL_WMASK[8*b +: 8];
         end
      end
   end

   assign sel_word = sel_q;

   // R4: the select register only changes on a decoded write
   a_r4_hold_without_write : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sel_q));

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
   import cfg_port_pkg::*;
#(
   parameter int unsigned TIMEOUT = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_rd,
   input  logic               io_wr,
   input  logic [BYTES_W-1:0] io_be,
   input  logic [WORD_W-1:0]  io_wdata,
   input  logic               hit_sel,
   input  logic               hit_dat,
   input  logic [WORD_W-1:0]  sel_word,
   output logic               sel_wr,
   output logic [WORD_W-1:0]  io_rdata,
   output logic               io_ready,
   output logic               cfg_req,
   output logic               cfg_we,
   output logic [BYTES_W-1:0] cfg_be,
   output logic [WORD_W-1:0]  cfg_wdata,
   input  logic [WORD_W-1:0]  cfg_rdata,
   input  logic               cfg_done
);

   bridge_state_e       state_q;
   logic                we_q;
   logic [BYTES_W-1:0]  be_q;
   logic [WORD_W-1:0]   wdata_q;
   logic [WORD_W-1:0]   rdata_q;
   logic                start;
   logic                go_cfg;
   logic                sel_en;
   logic                expired;

   assign sel_en = sel_word[SEL_EN_BIT];
   assign start  = (state_q == ST_IDLE) && (io_rd || io_wr);
   assign go_cfg = hit_dat && sel_en;
   assign sel_wr = start && io_wr && hit_sel;

   // Timeout variant chosen by parameter: a window counter, or none at all.
   if (TIMEOUT > 0) begin : g_timeout
      localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (state_q != ST_WAIT) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign expired = (state_q == ST_WAIT) && (cnt_q == LAST);

      // R9: an unanswered read ends with all ones at the window's end
      a_r9_timeout_ones : assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_req && expired && !cfg_done && !cfg_we) |=> (io_ready && io_rdata == '1));
   end else begin : g_no_timeout
      assign expired = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         be_q    <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (go_cfg) begin
                     state_q <= ST_WAIT;
                     we_q    <= io_wr;
                     be_q    <= io_be;
                     wdata_q <= io_wdata;
                  end else begin
                     state_q <= ST_RESP;
                     if (io_rd && hit_sel) begin
                        rdata_q <= sel_word;
                     end else if (io_rd && hit_dat) begin
                        rdata_q <= '1;
                     end else begin
                        rdata_q <= '0;
                     end
                  end
               end
            end
            ST_WAIT: begin
               if (cfg_done) begin
                  state_q <= ST_RESP;
                  rdata_q <= we_q ? '0 : cfg_rdata;
               end else if (expired) begin
                  state_q <= ST_RESP;
                  rdata_q <= we_q ? '0 : '1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign cfg_req   = (state_q == ST_WAIT);
   assign cfg_we    = we_q;
   assign cfg_be    = be_q;
   assign cfg_wdata = wdata_q;
   assign io_ready  = (state_q == ST_RESP);
   assign io_rdata  = io_ready ? rdata_q : '0;

   // R3: writing the select register never launches a request
   a_r3_sel_write_no_req : assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> !cfg_req);

   // R7: a request only starts while the enable flag is set
   a_r7_req_needs_enable : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req) |-> sel_en);

   // R8: ready is a single-cycle pulse
   a_r8_ready_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      io_ready |=> !io_ready);

   // R8: completion follows the target's done by one cycle
   a_r8_ready_after_done : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_done) |=> (io_ready && !cfg_req));

   // R10: request payload holds while pending
   a_r10_payload_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_done && !expired) |=>
         (cfg_req && $stable(cfg_we) && $stable(cfg_be) && $stable(cfg_wdata)));

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cfg_port_pkg::*;
#(
   parameter int unsigned IO_ADDR_W = 16,
   parameter int unsigned SEL_PORT  = 32'h0CF8,
   parameter int unsigned DAT_PORT  = 32'h0CFC,
   parameter int unsigned TIMEOUT   = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic                 io_rd,
   input  logic                 io_wr,
   input  logic [3:0]           io_be,
   input  logic [31:0]          io_wdata,
   output logic [31:0]          io_rdata,
   output logic                 io_ready,
   output logic                 cfg_req,
   output logic                 cfg_we,
   output logic [7:0]           cfg_bus,
   output logic [4:0]           cfg_dev,
   output logic [2:0]           cfg_func,
   output logic [5:0]           cfg_reg,
   output logic [3:0]           cfg_be,
   output logic [31:0]          cfg_wdata,
   input  logic [31:0]          cfg_rdata,
   input  logic                 cfg_done
);

   logic              hit_sel;
   logic              hit_dat;
   logic              sel_wr;
   logic [WORD_W-1:0] sel_word;

   cfg_io_decode #(
      .IO_ADDR_W (IO_ADDR_W),
      .SEL_PORT  (SEL_PORT),
      .DAT_PORT  (DAT_PORT)
   ) u_decode (
      .io_addr (io_addr),
      .hit_sel (hit_sel),
      .hit_dat (hit_dat)
   );

   cfg_addr_reg u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel_wr),
      .wr_be    (io_be),
      .wr_data  (io_wdata),
      .sel_word (sel_word)
   );

   cfg_port_ctrl #(
      .TIMEOUT (TIMEOUT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_rd     (io_rd),
      .io_wr     (io_wr),
      .io_be     (io_be),
      .io_wdata  (io_wdata),
      .hit_sel   (hit_sel),
      .hit_dat   (hit_dat),
      .sel_word  (sel_word),
      .sel_wr    (sel_wr),
      .io_rdata  (io_rdata),
      .io_ready  (io_ready),
      .cfg_req   (cfg_req),
      .cfg_we    (cfg_we),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .cfg_done  (cfg_done)
   );

   assign cfg_bus  = sel_word[SEL_BUS_LSB +: 8];
   assign cfg_dev  = sel_word[SEL_DEV_LSB +: 5];
   assign cfg_func = sel_word[SEL_FN_LSB  +: 3];
   assign cfg_reg  = sel_word[SEL_REG_LSB +: 6];

   // R10: target coordinates hold while a request is pending
   a_r10_target_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && !cfg_done) |=>
         ($stable(cfg_bus) && $stable(cfg_dev) && $stable(cfg_func) && $stable(cfg_reg)));

   // R1: a strobe to an undecoded address never starts a request
   a_r1_undecoded_no_req : assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_req && !io_ready && (io_rd || io_wr) && !hit_sel && !hit_dat) |=> !cfg_req);

endmodule

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [3:0]  io_be = '0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        io_ready;
   logic        cfg_req;
   logic        cfg_we;
   logic [7:0]  cfg_bus;
   logic [4:0]  cfg_dev;
   logic [2:0]  cfg_func;
   logic [5:0]  cfg_reg;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata = '0;
   logic        cfg_done = 1'b0;

   int errors = 0;
   int checks = 0;

   cfg_port_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_done(cfg_done)
   );

   always #5 clk = ~clk;

   // ---------------- target model ----------------
   int          tgt_delay = 0;
   int          wait_cnt = 0;
   int          txn_cnt = 0;
   int          req_cycles = 0;
   int          log_cnt = 0;
   logic        prev_req = 1'b0;
   logic        log_we;
   logic [7:0]  log_bus;
   logic [4:0]  log_dev;
   logic [2:0]  log_func;
   logic [5:0]  log_reg;
   logic [3:0]  log_be;
   logic [31:0] log_wdata;

   function automatic logic [31:0] model_word(input logic [7:0] b, input logic [4:0] d,
                                              input logic [2:0] f, input logic [5:0] r);
      return {8'hC0, b, d, f, r, 2'b01};
   endfunction

   always @(negedge clk) begin
      cfg_done <= 1'b0;
      if (cfg_req && !prev_req) begin
         txn_cnt    <= txn_cnt + 1;
         req_cycles <= 1;
      end else if (cfg_req) begin
         req_cycles <= req_cycles + 1;
      end
      prev_req <= cfg_req;
      // device 31 never answers
      if (cfg_req && !cfg_done && cfg_dev != 5'd31) begin
         if (wait_cnt == tgt_delay) begin
            cfg_done  <= 1'b1;
            cfg_rdata <= model_word(cfg_bus, cfg_dev, cfg_func, cfg_reg);
            wait_cnt  <= 0;
            log_cnt   <= log_cnt + 1;
            log_we    <= cfg_we;
            log_bus   <= cfg_bus;
            log_dev   <= cfg_dev;
            log_func  <= cfg_func;
            log_reg   <= cfg_reg;
            log_be    <= cfg_be;
            log_wdata <= cfg_wdata;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end else if (!cfg_req) begin
         wait_cnt <= 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic io_access(input bit wr, input logic [15:0] a, input logic [3:0] be,
                            input logic [31:0] wd, output logic [31:0] rd, output int lat);
      @(negedge clk);
      io_addr  = a;
      io_be    = be;
      io_wdata = wd;
      io_wr    = wr;
      io_rd    = !wr;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!io_ready && lat < 300);
      rd = io_rdata;
      io_rd = 1'b0;
      io_wr = 1'b0;
   endtask

   // op: 0 write, 1 read and compare, 2 data-port write checked via target log
   localparam int NV = 10;
   localparam logic [85:0] VEC [0:NV-1] = '{
      {2'd0, 16'h0CF8, 4'hF, 32'h8001_2A0C, 32'h0000_0000},
      {2'd1, 16'h0CF8, 4'hF, 32'h0000_0000, 32'h8001_2A0C},
      {2'd1, 16'h0CFC, 4'hF, 32'h0000_0000, 32'hC001_2A0D},
      {2'd2, 16'h0CFC, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {2'd1, 16'h0080, 4'hF, 32'h0000_0000, 32'h0000_0000},
      {2'd0, 16'h0CF8, 4'hF, 32'h7F12_3457, 32'h0000_0000},
      {2'd1, 16'h0CF8, 4'hF, 32'h0000_0000, 32'h0012_3454},
      {2'd1, 16'h0CFC, 4'hF, 32'h0000_0000, 32'hFFFF_FFFF},
      {2'd0, 16'h0CF8, 4'h1, 32'h0000_00FC, 32'h0000_0000},
      {2'd1, 16'h0CF8, 4'hF, 32'h0000_0000, 32'h0012_34FC}
   };

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int lat;
      int t0;
      int l0;

      // reset state (R4)
      repeat (3) @(negedge clk);
      check(io_ready == 1'b0 && cfg_req == 1'b0, "R4 reset ready/req", {30'd0, io_ready, cfg_req}, 32'd0);
      check(io_rdata == 32'd0, "R8 rdata idle zero", io_rdata, 32'd0);
      rst_n = 1'b1;
      io_access(1'b0, 16'h0CF8, 4'hF, 32'd0, rd, lat);
      check(rd == 32'd0, "R4 select cleared by reset", rd, 32'd0);
      check(lat == 1, "R1 select read latency", lat, 32'd1);

      // vector table: R1 R2 R4 R5 R6 R7
      t0 = txn_cnt;
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [15:0] a;
         logic [3:0]  be;
         logic [31:0] wd;
         logic [31:0] ex;
         {op, a, be, wd, ex} = VEC[i];
         io_access(op != 2'd1, a, be, wd, rd, lat);
         if (op == 2'd1) begin
            check(rd == ex, $sformatf("R2/R5/R7/R1 vector %0d read", i), rd, ex);
         end else if (op == 2'd2) begin
            check(log_we && log_wdata == ex, $sformatf("R6 vector %0d write data", i), log_wdata, ex);
         end
      end
      check(txn_cnt - t0 == 2, "R7 table request count", txn_cnt - t0, 32'd2);

      // R3: select write starts nothing
      t0 = txn_cnt;
      io_access(1'b1, 16'h0CF8, 4'hF, 32'h8010_3980, rd, lat);
      repeat (3) @(negedge clk);
      check(txn_cnt == t0, "R3 select write no request", txn_cnt, t0);

      // R5 / R8: read with target delay 5
      tgt_delay = 5;
      io_access(1'b0, 16'h0CFC, 4'b0110, 32'd0, rd, lat);
      check(lat == 7, "R8 ready after done latency", lat, 32'd7);
      check(rd == 32'hC010_3981, "R5 read data", rd, 32'hC010_3981);
      check({log_we, log_bus, log_dev, log_func, log_reg} == {1'b0, 8'h10, 5'd7, 3'd1, 6'h20},
            "R5 request fields", {11'd0, log_we, log_bus, log_dev, log_func, log_reg},
            {11'd0, 1'b0, 8'h10, 5'd7, 3'd1, 6'h20});
      check(log_be == 4'b0110, "R5 byte enables", {28'd0, log_be}, 32'h6);

      // R6: write with delay 0
      tgt_delay = 0;
      io_access(1'b1, 16'h0CFC, 4'b1001, 32'h1234_5678, rd, lat);
      check(lat == 2, "R6 write latency", lat, 32'd2);
      check(log_we && log_wdata == 32'h1234_5678 && log_be == 4'b1001, "R6 write payload",
            log_wdata, 32'h1234_5678);

      // R9: absent device times out
      io_access(1'b1, 16'h0CF8, 4'hF, 32'h8000_F800, rd, lat);
      l0 = log_cnt;
      io_access(1'b0, 16'h0CFC, 4'hF, 32'd0, rd, lat);
      check(rd == 32'hFFFF_FFFF, "R9 timeout read data", rd, 32'hFFFF_FFFF);
      check(lat == 65, "R9 timeout latency", lat, 32'd65);
      check(req_cycles == 64, "R9 request window", req_cycles, 32'd64);
      io_access(1'b1, 16'h0CFC, 4'hF, 32'h5555_AAAA, rd, lat);
      check(lat == 65 && log_cnt == l0, "R9 timeout write completes", lat, 32'd65);

      // R9 corner: answer on the last cycle of the window, register 63
      io_access(1'b1, 16'h0CF8, 4'hF, 32'h8000_18FC, rd, lat);
      tgt_delay = 63;
      io_access(1'b0, 16'h0CFC, 4'hF, 32'd0, rd, lat);
      check(rd == 32'hC000_18FD, "R9 done on last cycle wins", rd, 32'hC000_18FD);
      check(lat == 65, "R9 last-cycle latency", lat, 32'd65);
      tgt_delay = 0;

      // R7: write with enable clear is discarded
      io_access(1'b1, 16'h0CF8, 4'hF, 32'h0000_18FC, rd, lat);
      t0 = txn_cnt;
      l0 = log_cnt;
      io_access(1'b1, 16'h0CFC, 4'hF, 32'h0BAD_0BAD, rd, lat);
      check(lat == 1 && txn_cnt == t0 && log_cnt == l0, "R7 disabled write discarded",
            txn_cnt, t0);

      // R1: neighbouring byte addresses are not decoded
      io_access(1'b1, 16'h0CF9, 4'hF, 32'hFFFF_FFFF, rd, lat);
      check(lat == 1, "R1 undecoded write completes", lat, 32'd1);
      io_access(1'b0, 16'h0CF8, 4'hF, 32'd0, rd, lat);
      check(rd == 32'h0000_18FC, "R1 select untouched by 0xCF9", rd, 32'h0000_18FC);
      io_access(1'b0, 16'h0CFD, 4'hF, 32'd0, rd, lat);
      check(rd == 32'd0 && txn_cnt == t0, "R1 undecoded read zero", rd, 32'd0);

      // R4: reset clears a populated select register
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      io_access(1'b0, 16'h0CF8, 4'hF, 32'd0, rd, lat);
      check(rd == 32'd0, "R4 reset clears select", rd, 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule